// File: doc/BRIEF.md
# SD Host Single-Address DMA Engine

This block moves the data of one SD block transfer between the card-side data buffer and system memory over one contiguous address range. Software programs a start address, a block length with a boundary code, a block count and a direction, then pulses `start`. The DMA select field must be `00`. For a card-to-memory transfer the engine packs bytes from the card buffer into little-endian words and writes them to memory. For a memory-to-card transfer it reads words and streams their bytes to the card buffer, lowest byte first.

The address advances by one word for each memory beat that is accepted. Suppose that after a word the next address lands on a multiple of the programmed power-of-two boundary and more words remain. The engine then stops, pulses `dma_int`, and waits in a paused state. `addr_rd` shows the address it would use next. A write to the address register resumes the transfer from the written address, so writing back the read value continues seamlessly. After the final word the engine pulses `xfer_done` and goes idle.

The states are IDLE, GATHER (collecting card bytes), MEM_WR (memory write beat), MEM_RD (memory read beat), SCATTER (sending bytes to the card) and PAUSE. The transitions are:
- IDLE→GATHER or IDLE→MEM_RD on an accepted start with a non-empty transfer.
- GATHER→MEM_WR when the last byte of a word arrives.
- MEM_WR→GATHER, MEM_WR→PAUSE or MEM_WR→IDLE when the write is acknowledged.
- MEM_RD→SCATTER when the read is acknowledged.
- SCATTER→MEM_RD, SCATTER→PAUSE or SCATTER→IDLE after the last byte of a word.
- PAUSE→GATHER or PAUSE→MEM_RD on an address write.

Top module: `sd_sdma_engine`

## Requirements
- R1: After reset `busy`, `mem_req`, `rx_ready`, `tx_valid`, `dma_int` and `xfer_done` are 0 and `addr_rd` is 0.
- R2: `start` is accepted only in IDLE and only when `dma_mode` is `00`. With any other mode value (`01`, `10`, `11`) the engine stays idle and issues no traffic.
- R3: Card-to-memory (`dir_to_mem`=1): four card bytes form one word, with the first byte in bits 7:0. Each word is written at the current address, and the address rises by 4 for each acknowledged beat.
- R4: Memory-to-card (`dir_to_mem`=0): each word that is read is sent to the card as four bytes, bits 7:0 first.
- R5: A memory request keeps `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ack`.
- R6: The word count equals the number of blocks × floor(length/4). Length is `blk_cfg[11:0]` in bytes. The number of blocks is `blk_count` when `count_en`=1, and 1 otherwise. `xfer_done` pulses for one cycle once the last word has completed, and `busy` is then 0.
- R7: The boundary is 4096 << code bytes, where code is `blk_cfg[14:12]`. Suppose the address following a word is a multiple of the boundary and words remain. The engine then pulses `dma_int`, stops all traffic, and holds `addr_rd` at that next address.
- R8: An address write in PAUSE resumes from the written address. An address write while a transfer is running is ignored.
- R9: A final word that ends on a boundary raises only `xfer_done`, never `dma_int`. A transfer that starts on a boundary does not pause.
- R10: A transfer of zero words (count enabled with count 0, or length below 4) pulses `xfer_done` in the cycle after `start` and issues no traffic.
- R11: The length, code, count and direction are captured at `start`. Changes to these inputs during a transfer have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| dma_mode | input | 2 | DMA select, `00` = this engine |
| dir_to_mem | input | 1 | 1 card→memory, 0 memory→card |
| count_en | input | 1 | Use `blk_count` |
| blk_cfg | input | 15 | [11:0] block length, [14:12] boundary code |
| blk_count | input | 16 | Number of blocks |
| addr_wr | input | 1 | System address write strobe |
| addr_wdata | input | 32 | System address write value |
| addr_rd | output | 32 | Next address to be used |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Write word |
| mem_ack | input | 1 | Request accepted |
| mem_rdata | input | 32 | Read word, valid with `mem_ack` |
| rx_valid | input | 1 | Card byte available |
| rx_data | input | 8 | Card byte |
| rx_ready | output | 1 | Engine takes a card byte |
| tx_valid | output | 1 | Byte for card available |
| tx_data | output | 8 | Byte for card |
| tx_ready | input | 1 | Card buffer takes the byte |
| busy | output | 1 | Engine not idle (pause included) |
| dma_int | output | 1 | Boundary pause pulse |
| xfer_done | output | 1 | Transfer complete pulse |

## Verification
The hardest conditions to reach from the ports are a boundary crossing partway through a transfer, and a final word that lands exactly on a boundary. The 4 KiB default boundary would otherwise take a thousand beats. The bench therefore writes start addresses a few words below a boundary, for example 0x0FE0 or 0x7FFF0 with code 7, so that the crossing falls in the middle, at the end, or twice. One vector resumes at an unrelated address to check that the engine continues from the written value.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATHER,
        ST_MEM_WR,
        ST_MEM_RD,
        ST_SCATTER,
        ST_PAUSE
    } sdma_state_t;

    localparam logic [1:0] MODE_SIMPLE = 2'b00;

endpackage

// File: rtl/sdma_addr_gen.sv
module sdma_addr_gen #(
    parameter int ADDR_W        = 32,
    parameter int CODE_W        = 3,
    parameter int BND_BASE_LOG2 = 12,
    parameter int STEP_BYTES    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    input  logic              code_set,
    input  logic [CODE_W-1:0] code_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              bnd_cur,
    output logic              bnd_nxt
);
    logic [CODE_W-1:0] code_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] bnd_mask;
    logic [ADDR_W-1:0] nxt_addr;

    assign bnd_mask = (ADDR_W'(1) << (BND_BASE_LOG2 + int'(code_q))) - ADDR_W'(1);
    assign nxt_addr = addr_q + ADDR_W'(STEP_BYTES);
    assign bnd_cur  = (addr_q & bnd_mask) == '0;
    assign bnd_nxt  = (nxt_addr & bnd_mask) == '0;
    assign cur_addr = addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            code_q <= '0;
        end else begin
            if (code_set)
                code_q <= code_in;
            if (load)
                addr_q <= load_val;
            else if (adv)
                addr_q <= nxt_addr;
        end
    end

    // R3: each accepted beat moves the address by one word
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !load |=> cur_addr == $past(cur_addr) + ADDR_W'(STEP_BYTES));

    // R8: without a load or beat the address does not move
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv && !load |=> $stable(cur_addr));

endmodule

// File: rtl/sdma_xfer_count.sv
module sdma_xfer_count #(
    parameter int LEN_W     = 12,
    parameter int CNT_W     = 16,
    parameter int LANE_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             cnt_en_in,
    input  logic             step,
    output logic             empty,
    output logic             last
);
    logic [LEN_W-1:0] wpb_in;
    logic [CNT_W-1:0] blocks_in;
    logic [LEN_W-1:0] wpb_q;
    logic [LEN_W-1:0] word_idx;
    logic [CNT_W-1:0] blk_left;
    logic             blk_end;

    assign wpb_in    = len_in >> LANE_LOG2;
    assign blocks_in = cnt_en_in ? cnt_in : CNT_W'(1);
    assign empty     = (wpb_in == '0) || (blocks_in == '0);
    assign blk_end   = word_idx == (wpb_q - LEN_W'(1));
    assign last      = blk_end && (blk_left == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wpb_q    <= '0;
            word_idx <= '0;
            blk_left <= '0;
        end else if (load) begin
            wpb_q    <= wpb_in;
            word_idx <= '0;
            blk_left <= blocks_in;
        end else if (step) begin
            if (blk_end) begin
                word_idx <= '0;
                blk_left <= blk_left - CNT_W'(1);
            end else begin
                word_idx <= word_idx + LEN_W'(1);
            end
        end
    end

    // R6: a word never completes once every block is used up
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> blk_left != '0);

endmodule

// File: rtl/sdma_byte_lane.sv
module sdma_byte_lane #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              gather_en,
    input  logic [7:0]        gather_byte,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_word,
    input  logic              scatter_en,
    output logic [DATA_W-1:0] word,
    output logic              lane_last,
    output logic [7:0]        out_byte
);
    localparam int LANES = DATA_W / 8;
    localparam int IDX_W = $clog2(LANES);

    logic [DATA_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;

    assign word      = word_q;
    assign lane_last = idx_q == IDX_W'(LANES - 1);
    assign out_byte  = word_q[8*idx_q +: 8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
        end else if (clr) begin
            idx_q <= '0;
        end else if (load_en) begin
            word_q <= load_word;
            idx_q  <= '0;
        end else if (gather_en || scatter_en) begin
            if (gather_en)
                word_q[8*idx_q +: 8] <= gather_byte;
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    // R4: a word load never coincides with a byte move
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> !(gather_en || scatter_en));

endmodule

// File: rtl/sd_sdma_engine.sv
module sd_sdma_engine
    import sdma_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int DATA_W        = 32,
    parameter int LEN_W         = 12,
    parameter int CNT_W         = 16,
    parameter int CODE_W        = 3,
    parameter int BND_BASE_LOG2 = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [1:0]              dma_mode,
    input  logic                    dir_to_mem,
    input  logic                    count_en,
    input  logic [LEN_W+CODE_W-1:0] blk_cfg,
    input  logic [CNT_W-1:0]        blk_count,
    input  logic                    addr_wr,
    input  logic [ADDR_W-1:0]       addr_wdata,
    output logic [ADDR_W-1:0]       addr_rd,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic                    mem_ack,
    input  logic [DATA_W-1:0]       mem_rdata,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_data,
    output logic                    rx_ready,
    output logic                    tx_valid,
    output logic [7:0]              tx_data,
    input  logic                    tx_ready,
    output logic                    busy,
    output logic                    dma_int,
    output logic                    xfer_done
);
    localparam int LANES     = DATA_W / 8;
    localparam int LANE_LOG2 = $clog2(LANES);
    localparam int CFG_W     = LEN_W + CODE_W;

    sdma_state_t       state_q, state_d;
    logic              dir_q;
    logic              done_q, done_d, dma_q, dma_d;
    logic [LEN_W-1:0]  len_in;
    logic [CODE_W-1:0] code_in;
    logic [ADDR_W-1:0] cur_addr;
    logic              bnd_cur, bnd_nxt;
    logic              empty, last_word;
    logic [DATA_W-1:0] lane_word;
    logic              lane_last;
    logic [7:0]        lane_byte;
    logic              start_ok, rx_take, tx_take, rd_take, wr_take, word_end;
    logic              addr_load;

    assign len_in    = blk_cfg[LEN_W-1:0];
    assign code_in   = blk_cfg[CFG_W-1:LEN_W];
    assign start_ok  = (state_q == ST_IDLE) && start && (dma_mode == MODE_SIMPLE);
    assign rx_take   = (state_q == ST_GATHER) && rx_valid;
    assign tx_take   = (state_q == ST_SCATTER) && tx_ready;
    assign rd_take   = (state_q == ST_MEM_RD) && mem_ack;
    assign wr_take   = (state_q == ST_MEM_WR) && mem_ack;
    assign word_end  = wr_take || (tx_take && lane_last);
    assign addr_load = addr_wr && ((state_q == ST_IDLE) || (state_q == ST_PAUSE));

    sdma_addr_gen #(
        .ADDR_W(ADDR_W), .CODE_W(CODE_W),
        .BND_BASE_LOG2(BND_BASE_LOG2), .STEP_BYTES(LANES)
    ) u_addr (
        .clk(clk), .rst_n(rst_n),
        .load(addr_load), .load_val(addr_wdata),
        .adv(rd_take || wr_take),
        .code_set(start_ok), .code_in(code_in),
        .cur_addr(cur_addr), .bnd_cur(bnd_cur), .bnd_nxt(bnd_nxt)
    );

    sdma_xfer_count #(
        .LEN_W(LEN_W), .CNT_W(CNT_W), .LANE_LOG2(LANE_LOG2)
    ) u_count (
        .clk(clk), .rst_n(rst_n),
        .load(start_ok), .len_in(len_in), .cnt_in(blk_count),
        .cnt_en_in(count_en), .step(word_end),
        .empty(empty), .last(last_word)
    );

    sdma_byte_lane #(
        .DATA_W(DATA_W)
    ) u_lane (
        .clk(clk), .rst_n(rst_n),
        .clr(start_ok),
        .gather_en(rx_take), .gather_byte(rx_data),
        .load_en(rd_take), .load_word(mem_rdata),
        .scatter_en(tx_take),
        .word(lane_word), .lane_last(lane_last), .out_byte(lane_byte)
    );

    // next-state and pulse decisions
    always_comb begin
        state_d = state_q;
        done_d  = 1'b0;
        dma_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) begin
                    if (empty)
                        done_d = 1'b1;
                    else
                        state_d = dir_to_mem ? ST_GATHER : ST_MEM_RD;
                end
            end
            ST_GATHER: begin
                if (rx_take && lane_last)
                    state_d = ST_MEM_WR;
            end
            ST_MEM_WR: begin
                if (mem_ack) begin
                    if (last_word) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else if (bnd_nxt) begin
                        state_d = ST_PAUSE;
                        dma_d   = 1'b1;
                    end else begin
                        state_d = ST_GATHER;
                    end
                end
            end
            ST_MEM_RD: begin
                if (mem_ack)
                    state_d = ST_SCATTER;
            end
            ST_SCATTER: begin
                if (tx_take && lane_last) begin
                    if (last_word) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else if (bnd_cur) begin
                        state_d = ST_PAUSE;
                        dma_d   = 1'b1;
                    end else begin
                        state_d = ST_MEM_RD;
                    end
                end
            end
            ST_PAUSE: begin
                if (addr_wr)
                    state_d = dir_q ? ST_GATHER : ST_MEM_RD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
            done_q  <= 1'b0;
            dma_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
            dma_q   <= dma_d;
            if (start_ok)
                dir_q <= dir_to_mem;
        end
    end

    // outputs
    always_comb begin
        mem_req   = (state_q == ST_MEM_WR) || (state_q == ST_MEM_RD);
        mem_we    = state_q == ST_MEM_WR;
        mem_addr  = cur_addr;
        mem_wdata = lane_word;
        rx_ready  = state_q == ST_GATHER;
        tx_valid  = state_q == ST_SCATTER;
        tx_data   = lane_byte;
        busy      = state_q != ST_IDLE;
        addr_rd   = cur_addr;
        dma_int   = dma_q;
        xfer_done = done_q;
    end

    // R5: request fields hold until acknowledged
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata));

    // R6: completion leaves the engine idle
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !busy);

    // R9: never pause and complete on the same word
    a_r9_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_int && xfer_done));

    // R2: no traffic while idle
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_req || rx_ready || tx_valid));

    // R7: a pause stops all traffic until resumed
    a_r7_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dma_int |-> busy && !mem_req && !rx_ready && !tx_valid);

    a_r7_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, rx_ready, tx_valid}));

endmodule

// File: tb/sd_sdma_engine_bench.sv
module sd_sdma_engine_bench;

    typedef struct packed {
        logic        dir;
        logic [2:0]  code;
        logic [11:0] len;
        logic [15:0] cnt;
        logic        en;
        logic [31:0] base;
        logic [31:0] resume;
        logic [15:0] exp_words;
        logic [7:0]  exp_pauses;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [0:NVEC-1] = '{
        // R3 R7: mid-transfer pause, card to memory
        '{1'b1, 3'd0, 12'd16, 16'd3, 1'b1, 32'h0000_0FE0, 32'h0, 16'd12, 8'd1},
        // R4 R7: memory to card pause
        '{1'b0, 3'd0, 12'd8,  16'd4, 1'b1, 32'h0000_1FF0, 32'h0, 16'd8,  8'd1},
        // R9 R6: count disabled, last word on boundary
        '{1'b1, 3'd1, 12'd32, 16'd2, 1'b0, 32'h0000_1FE0, 32'h0, 16'd8,  8'd0},
        // R9: start on a boundary
        '{1'b0, 3'd0, 12'd12, 16'd2, 1'b1, 32'h0000_3000, 32'h0, 16'd6,  8'd0},
        // R8: resume at another address
        '{1'b1, 3'd2, 12'd4,  16'd5, 1'b1, 32'h0000_7FF8, 32'h0000_9000, 16'd5, 8'd1},
        // R7: largest boundary code
        '{1'b0, 3'd7, 12'd64, 16'd1, 1'b1, 32'h0007_FFF0, 32'h0, 16'd16, 8'd1},
        // R10: length below one word
        '{1'b1, 3'd0, 12'd3,  16'd2, 1'b1, 32'h0000_4000, 32'h0, 16'd0,  8'd0},
        // R10: zero block count
        '{1'b0, 3'd0, 12'd16, 16'd0, 1'b1, 32'h0000_5000, 32'h0, 16'd0,  8'd0},
        // R8 R7: two pauses, resumed elsewhere in between
        '{1'b1, 3'd0, 12'd4,  16'd3, 1'b1, 32'h0000_0FFC, 32'h0000_1FFC, 16'd3, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  dma_mode = 2'b00;
    logic        dir_to_mem = 1'b0;
    logic        count_en = 1'b0;
    logic [14:0] blk_cfg = '0;
    logic [15:0] blk_count = '0;
    logic        addr_wr = 1'b0;
    logic [31:0] addr_wdata = '0;
    logic [31:0] addr_rd;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        busy, dma_int, xfer_done;

    int checks = 0;
    int fails = 0;
    int gcyc = 0;
    int ack_count = 0;
    int wr_words = 0;
    int rd_words = 0;
    int rx_k = 0;
    int tx_k = 0;
    logic [31:0] exp_addr = '0;
    logic [31:0] expw [0:1023];

    always #5 clk = ~clk;

    sd_sdma_engine u_sd_sdma_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .dma_mode(dma_mode),
        .dir_to_mem(dir_to_mem), .count_en(count_en), .blk_cfg(blk_cfg),
        .blk_count(blk_count), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .addr_rd(addr_rd), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .busy(busy), .dma_int(dma_int),
        .xfer_done(xfer_done)
    );

    function automatic logic [7:0] src_byte(int k);
        return 8'(k * 7 + 3);
    endfunction

    function automatic logic [31:0] mem_val(logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'hA5C3_0F96;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            gcyc++;
            if (gcyc > 150000) begin
                fails++;
                $display("FAIL watchdog: actual %0d expected <150000", gcyc);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    // memory responder: R3 R5 data/address checks
    initial begin
        int wait_c;
        wait_c = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst_n && mem_req) begin
                check(mem_addr == exp_addr, "R5 request address", mem_addr, exp_addr);
                if (wait_c == 0) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        check(mem_wdata == {src_byte(4*wr_words+3), src_byte(4*wr_words+2),
                                            src_byte(4*wr_words+1), src_byte(4*wr_words)},
                              "R3 write data", mem_wdata,
                              {src_byte(4*wr_words+3), src_byte(4*wr_words+2),
                               src_byte(4*wr_words+1), src_byte(4*wr_words)});
                        wr_words++;
                    end else begin
                        mem_rdata = mem_val(mem_addr);
                        expw[rd_words % 1024] = mem_rdata;
                        rd_words++;
                    end
                    exp_addr = exp_addr + 32'd4;
                    ack_count++;
                    wait_c = ack_count % 3;
                end else begin
                    wait_c--;
                end
            end
        end
    end

    // card byte source
    initial begin
        bit took;
        took = 1'b0;
        forever begin
            @(negedge clk);
            if (took) rx_k++;
            rx_data  = src_byte(rx_k);
            rx_valid = (gcyc % 3) != 2;
            took     = rx_valid && rx_ready;
        end
    end

    // card byte sink: R4
    initial begin
        forever begin
            @(negedge clk);
            tx_ready = (gcyc % 4) != 1;
            if (tx_valid && tx_ready) begin
                logic [31:0] w;
                w = expw[(tx_k / 4) % 1024] >> (8 * (tx_k % 4));
                check(tx_data == w[7:0], "R4 card byte", {24'h0, tx_data}, {24'h0, w[7:0]});
                tx_k++;
            end
        end
    end

    task automatic run_vec(input vec_t v, input int idx);
        int acks0, pauses, cyc;
        bit done;
        acks0 = ack_count;
        pauses = 0;
        cyc = 0;
        done = 1'b0;
        @(negedge clk);
        addr_wr = 1'b1;
        addr_wdata = v.base;
        exp_addr = v.base;
        @(negedge clk);
        addr_wr = 1'b0;
        blk_cfg = {v.code, v.len};
        blk_count = v.cnt;
        count_en = v.en;
        dir_to_mem = v.dir;
        dma_mode = 2'b00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 20000) begin
            if (xfer_done) begin
                done = 1'b1;
                if (v.exp_words == 0)
                    check(cyc == 0, "R10 immediate done", cyc, 0);
            end else begin
                if (dma_int) begin
                    logic [31:0] mask;
                    mask = (32'd1 << (12 + int'(v.code))) - 32'd1;
                    pauses++;
                    repeat (3) @(negedge clk);
                    check(!mem_req && !rx_ready && !tx_valid && busy,
                          "R7 paused quiet", {mem_req, rx_ready, tx_valid, busy}, 4'b0001);
                    check(addr_rd == exp_addr, "R7 pause address", addr_rd, exp_addr);
                    check((addr_rd & mask) == 0, "R7 pause aligned", addr_rd & mask, 0);
                    addr_wr = 1'b1;
                    addr_wdata = (pauses == 1 && v.resume != 0) ? v.resume : addr_rd;
                    exp_addr = addr_wdata;
                    @(negedge clk);
                    addr_wr = 1'b0;
                end
                @(negedge clk);
                cyc++;
            end
        end
        check(done, "R6 completion seen", {31'h0, done}, 1);
        check(ack_count - acks0 == int'(v.exp_words), "R6 word count",
              ack_count - acks0, v.exp_words);
        check(pauses == int'(v.exp_pauses), "R7 R9 pause count", pauses, v.exp_pauses);
        check(addr_rd == exp_addr, "R3 final address", addr_rd, exp_addr);
        check(!busy, "R6 idle after done", {31'h0, busy}, 0);
        if (idx < 0) $display("unreachable");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !mem_req && !rx_ready && !tx_valid && !dma_int && !xfer_done,
              "R1 reset outputs", {busy, mem_req, rx_ready, tx_valid, dma_int, xfer_done}, 0);
        check(addr_rd == 0, "R1 reset address", addr_rd, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++)
            run_vec(VECS[i], i);

        // R2: other DMA select values do not start the engine
        for (int m = 1; m < 4; m++) begin
            int a0;
            a0 = ack_count;
            @(negedge clk);
            dma_mode = 2'(m);
            dir_to_mem = 1'b0;
            blk_cfg = {3'd0, 12'd8};
            count_en = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (5) @(negedge clk);
            check(!busy && ack_count == a0 && !xfer_done, "R2 mode ignored",
                  {31'h0, busy}, 0);
        end
        dma_mode = 2'b00;

        // R8 R11: address write and config change while running are ignored
        begin
            int a0;
            a0 = ack_count;
            @(negedge clk);
            addr_wr = 1'b1;
            addr_wdata = 32'h0000_6000;
            exp_addr = 32'h0000_6000;
            @(negedge clk);
            addr_wr = 1'b0;
            blk_cfg = {3'd0, 12'd8};
            blk_count = 16'd2;
            count_en = 1'b1;
            dir_to_mem = 1'b1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            addr_wr = 1'b1;
            addr_wdata = 32'hDEAD_0000;
            blk_cfg = {3'd0, 12'd64};
            blk_count = 16'd9;
            dir_to_mem = 1'b0;
            @(negedge clk);
            addr_wr = 1'b0;
            for (int c = 0; c < 2000 && !xfer_done; c++)
                @(negedge clk);
            check(xfer_done, "R11 completion", {31'h0, xfer_done}, 1);
            check(ack_count - a0 == 4, "R11 latched length", ack_count - a0, 4);
            check(addr_rd == 32'h0000_6010, "R8 running write ignored",
                  addr_rd, 32'h0000_6010);
        end

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule